// File: doc/BRIEF.md
# Banked Data Memory Decoder

This block sits between the data-side address of an 8-bit Harvard microcontroller and its storage. Every access carries an 8-bit address, and the block works out where that address lands. The low half of the space (0x00–0x7F) is general RAM, spread over several banks. The top sixteen bytes (0xF0–0xFF) are a memory-mapped register file. Everything in between returns a fixed fill value and takes no writes.

The top register, at 0xFF, is the segment register. When banking is switched on, its low bits choose which RAM bank the low half reaches. Accesses flagged as stack accesses always reach bank 0, whatever the segment register holds.

In bank 0 the bytes 0x70–0x7F are not implemented. Reading them returns all-ones and raises a trap flag, so that a stack pointer running past the top of RAM is caught. Reads are combinational. Writes land on the rising clock edge.

Top module: `bank_mem_decode`

## Requirements
- R1: A synchronous reset clears all sixteen registers at 0xF0–0xFF to 0x00.
- R2: A write to 0xF0–0xFF updates register (address − 0xF0) at the clock edge. A read returns it combinationally, whatever the bank selection is.
- R3: With banking enabled (bank_en=1) and stack_acc=0, an access to 0x00–0x7F reaches RAM bank S[1:0], where S is the register at 0xFF. Banks 1 to 3 store all 128 bytes, including offsets 0x70–0x7F.
- R4: With banking disabled (bank_en=0), the low half always reaches bank 0, whatever S holds. S still reads and writes like any other register.
- R5: An access with stack_acc=1 to 0x00–0x7F reaches bank 0, whatever bank_en and S are.
- R6: An access that reaches bank 0 at 0x70–0x7F reads 0xFF and drives trap=1, and a write there is ignored. Every other access drives trap=0.
- R7: Reads of 0x80–0x8F return the fill value 0x5A. Writes there change no RAM byte and no register.
- R8: Reads of 0x90–0xEF return 0x00. Writes there change no RAM byte and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Data address |
| we | input | 1 | Write enable |
| wdata | input | 8 | Write data |
| stack_acc | input | 1 | Access is made through the stack pointer |
| bank_en | input | 1 | Banking enable |
| rdata | output | 8 | Read data |
| trap | output | 1 | Access hit the bank-0 guard region |

## Verification
Every byte of all four banks is written with a pattern computed from both the bank number and the offset, and then read back. A byte that lands in the wrong bank, or whose offset is folded, therefore shows up as a mismatch.

The same low addresses are then read under three conditions: banking disabled with S pointing at bank 3, stack accesses with S pointing at bank 2, and writes made through each of those paths. These reads separate the three rules that force bank 0 from ordinary bank selection.

Finally, the fill ranges and the guard bytes are written with values that differ from their fill. Afterwards the RAM bytes and registers that share the same low address bits are read back, which exposes any write that leaks through.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
    typedef enum logic [2:0] {
        RG_LOW_RAM,
        RG_GUARD,
        RG_UNDEF,
        RG_PERIPH,
        RG_REGS
    } region_e;
endpackage

// File: rtl/bmd_addr_map.sv
module bmd_addr_map
    import bmd_pkg::*;
#(
    parameter int        BANK_W      = 2,
    parameter logic [7:0] GUARD_LO   = 8'h70,
    parameter logic [7:0] PERIPH_LO  = 8'h90,
    parameter logic [7:0] REGS_LO    = 8'hF0
) (
    input  logic [7:0]        addr,
    input  logic              stack_acc,
    input  logic              bank_en,
    input  logic [BANK_W-1:0] s_bank,
    output region_e           region,
    output logic [BANK_W-1:0] eff_bank
);
    always_comb begin
        eff_bank = '0;
        region   = RG_UNDEF;
        if (!addr[7]) begin
            if (bank_en && !stack_acc) begin
                eff_bank = s_bank;
            end
            if (eff_bank == '0 && addr >= GUARD_LO) begin
                region = RG_GUARD;
            end else begin
                region = RG_LOW_RAM;
            end
        end else if (addr < PERIPH_LO) begin
            region = RG_UNDEF;
        end else if (addr < REGS_LO) begin
            region = RG_PERIPH;
        end else begin
            region = RG_REGS;
        end
    end
endmodule

// File: rtl/bmd_ram_banks.sv
module bmd_ram_banks #(
    parameter int DW     = 8,
    parameter int NBANK  = 4,
    parameter int DEPTH  = 128,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int AW     = $clog2(DEPTH),
    localparam int WORDS  = NBANK * DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [BANK_W-1:0] bank,
    input  logic [AW-1:0]     idx,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    typedef struct packed {
        logic [WORDS-1:0][DW-1:0] mem;
    } ram_state_t;

    ram_state_t state_d, state_q;
    logic [BANK_W+AW-1:0] flat;

    assign flat  = {bank, idx};
    assign rdata = state_q.mem[flat];

    always_comb begin
        state_d = state_q;
        if (we) begin
            state_d.mem[flat] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // RAM content moves only on an enabled write (R3, R6)
    p_ram_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(state_q.mem));
endmodule

// File: rtl/bmd_reg_file.sv
module bmd_reg_file #(
    parameter int DW   = 8,
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] seg_val
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } rf_state_t;

    rf_state_t state_d, state_q;

    assign rdata   = state_q.regs[idx];
    assign seg_val = state_q.regs[NREG-1];

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.regs = '0;
        end else if (we) begin
            state_d.regs[idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Registers hold unless written (R2)
    p_regs_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(state_q.regs));
endmodule

// File: rtl/bank_mem_decode.sv
module bank_mem_decode
    import bmd_pkg::*;
#(
    parameter int         DW          = 8,
    parameter int         NUM_BANKS   = 4,
    parameter logic [7:0] UNDEF_FILL  = 8'h5A,
    parameter logic [7:0] PERIPH_FILL = 8'h00,
    parameter logic [7:0] GUARD_FILL  = 8'hFF,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int NREG   = 16,
    localparam int HALF   = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          stack_acc,
    input  logic          bank_en,
    output logic [DW-1:0] rdata,
    output logic          trap
);
    region_e           region;
    logic [BANK_W-1:0] eff_bank;
    logic [DW-1:0]     seg_val;
    logic [DW-1:0]     ram_rdata;
    logic [DW-1:0]     rf_rdata;
    logic              ram_we;
    logic              rf_we;

    bmd_addr_map #(
        .BANK_W (BANK_W)
    ) u_map (
        .addr      (addr),
        .stack_acc (stack_acc),
        .bank_en   (bank_en),
        .s_bank    (seg_val[BANK_W-1:0]),
        .region    (region),
        .eff_bank  (eff_bank)
    );

    bmd_ram_banks #(
        .DW    (DW),
        .NBANK (NUM_BANKS),
        .DEPTH (HALF)
    ) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (ram_we),
        .bank  (eff_bank),
        .idx   (addr[6:0]),
        .wdata (wdata),
        .rdata (ram_rdata)
    );

    bmd_reg_file #(
        .DW   (DW),
        .NREG (NREG)
    ) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .idx     (addr[3:0]),
        .wdata   (wdata),
        .rdata   (rf_rdata),
        .seg_val (seg_val)
    );

    always_comb begin
        ram_we = we && (region == RG_LOW_RAM);
        rf_we  = we && (region == RG_REGS);
        trap   = (region == RG_GUARD);
        unique case (region)
            RG_LOW_RAM: rdata = ram_rdata;
            RG_GUARD:   rdata = GUARD_FILL;
            RG_UNDEF:   rdata = UNDEF_FILL;
            RG_PERIPH:  rdata = PERIPH_FILL;
            RG_REGS:    rdata = rf_rdata;
            default:    rdata = PERIPH_FILL;
        endcase
    end

    p_guard_fill_r6: assert property (@(posedge clk) disable iff (rst)
        trap |-> (rdata == GUARD_FILL && !ram_we));
    p_stack_bank0_r5: assert property (@(posedge clk) disable iff (rst)
        (stack_acc && !addr[7]) |-> (eff_bank == '0));
    p_high_no_ram_r7: assert property (@(posedge clk) disable iff (rst)
        addr[7] |-> !ram_we);
    p_mid_no_reg_r8: assert property (@(posedge clk) disable iff (rst)
        (addr[7] && addr < 8'hF0) |-> !rf_we);
endmodule

// File: tb/sim_bank_mem_decode.sv
module sim_bank_mem_decode;
    logic       clk = 0;
    logic       rst = 1;
    logic [7:0] addr = 0;
    logic       we = 0;
    logic [7:0] wdata = 0;
    logic       stack_acc = 0;
    logic       bank_en = 0;
    logic [7:0] rdata;
    logic       trap;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [4][128];

    always #5 clk = ~clk;

    bank_mem_decode u0 (
        .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata),
        .stack_acc(stack_acc), .bank_en(bank_en), .rdata(rdata), .trap(trap)
    );

    function automatic logic [7:0] pat(int b, int a);
        return 8'((a * 7 + b * 61 + 3) & 255);
    endfunction

    task automatic chk(string req, logic [7:0] a, logic [7:0] exp_d, logic exp_t);
        @(negedge clk);
        addr = a; we = 0;
        #1;
        checks++;
        if (rdata !== exp_d || trap !== exp_t) begin
            fails++;
            $display("FAIL %s addr=%h rdata=%h trap=%b expected rdata=%h trap=%b",
                     req, a, rdata, trap, exp_d, exp_t);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1;
        @(negedge clk);
        we = 0;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state of the register file
        for (int i = 0; i < 16; i++) chk("R1", 8'(8'hF0 + i), 8'h00, 1'b0);
        // R2: register write and read
        for (int i = 0; i < 15; i++) wr(8'(8'hF0 + i), 8'(i * 17 + 1));
        for (int i = 0; i < 15; i++) chk("R2", 8'(8'hF0 + i), 8'(i * 17 + 1), 1'b0);
        // R3: fill every bank, including guard attempts in bank 0
        bank_en = 1;
        for (int b = 0; b < 4; b++) begin
            wr(8'hFF, 8'(b));
            for (int a = 0; a < 128; a++) begin
                wr(8'(a), pat(b, a));
                model[b][a] = (b == 0 && a >= 8'h70) ? 8'hFF : pat(b, a);
            end
        end
        for (int b = 0; b < 4; b++) begin
            wr(8'hFF, 8'(b));
            for (int a = 0; a < 128; a++) begin
                if (b == 0 && a >= 8'h70) chk("R6", 8'(a), 8'hFF, 1'b1);
                else chk("R3", 8'(a), model[b][a], 1'b0);
            end
        end
        // R2: registers unaffected by bank selection
        for (int b = 0; b < 4; b++) begin
            wr(8'hFF, 8'(b));
            chk("R2", 8'hF3, 8'(3 * 17 + 1), 1'b0);
            chk("R2", 8'hFF, 8'(b), 1'b0);
        end
        // R4: banking disabled with S=3 reaches bank 0
        bank_en = 0;
        wr(8'hFF, 8'h03);
        chk("R4", 8'hFF, 8'h03, 1'b0);
        for (int a = 0; a < 128; a += 5) begin
            if (a >= 8'h70) chk("R4", 8'(a), 8'hFF, 1'b1);
            else chk("R4", 8'(a), model[0][a], 1'b0);
        end
        wr(8'h05, 8'hC1); model[0][5] = 8'hC1;
        bank_en = 1;
        wr(8'hFF, 8'h00);
        chk("R4", 8'h05, 8'hC1, 1'b0);
        wr(8'hFF, 8'h03);
        chk("R4", 8'h05, model[3][5], 1'b0);
        // R5: stack accesses reach bank 0 regardless of S
        wr(8'hFF, 8'h02);
        stack_acc = 1;
        for (int a = 0; a < 128; a += 7) begin
            if (a >= 8'h70) chk("R5", 8'(a), 8'hFF, 1'b1);
            else chk("R5", 8'(a), model[0][a], 1'b0);
        end
        wr(8'h10, 8'h3C); model[0][16] = 8'h3C;
        wr(8'h75, 8'h11);
        stack_acc = 0;
        chk("R5", 8'h10, model[2][16], 1'b0);
        chk("R3", 8'h75, model[2][8'h75], 1'b0);
        wr(8'hFF, 8'h00);
        chk("R5", 8'h10, 8'h3C, 1'b0);
        chk("R6", 8'h75, 8'hFF, 1'b1);
        // R7: 0x80-0x8F fill, writes ignored
        for (int a = 8'h80; a < 8'h90; a++) begin
            wr(8'(a), 8'hC3);
            chk("R7", 8'(a), 8'h5A, 1'b0);
        end
        for (int a = 0; a < 16; a++) chk("R7", 8'(a), model[0][a], 1'b0);
        // R8: 0x90-0xEF fill, writes ignored
        for (int a = 8'h90; a < 8'hF0; a++) begin
            wr(8'(a), 8'hA7);
            chk("R8", 8'(a), 8'h00, 1'b0);
        end
        for (int a = 16; a < 112; a += 3) chk("R8", 8'(a), model[0][a], 1'b0);
        for (int i = 0; i < 15; i++) chk("R8", 8'(8'hF0 + i), 8'(i * 17 + 1), 1'b0);
        chk("R8", 8'hFF, 8'h00, 1'b0);
        // R1: reset again clears registers
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        for (int i = 0; i < 16; i++) chk("R1", 8'(8'hF0 + i), 8'h00, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule